// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between program memory and the instruction decoders of a wide-issue core. It receives one fetch packet at a time. A fetch packet is 256 bits wide and holds eight 32-bit instruction slots. The block cuts the fetch packet into execute packets and issues one execute packet per clock. Bit 0 of each instruction links it to the instruction in the next slot up: a 1 keeps that next instruction in the same execute packet, and a 0 closes the packet.

Slot 0 is the lowest 32 bits of the fetch packet, and the scan runs upward from slot 0. The chaining bit of slot 7 is always treated as 0, so an execute packet never runs past the fetch boundary. The block requests a new fetch packet only when it holds none. This means every execute packet of the current fetch packet has been issued before the next one is asked for.

The dispatch output has three parts: a valid flag, an eight-bit mask of the occupied slots, and the 256-bit fetch packet with every unoccupied lane forced to zero. Each instruction stays in its own lane. A stall input freezes the current execute packet on the outputs.

Top module: `exec_bundle_dispatch`

## Requirements
- R1: After reset, `fetch_req` is 1, `disp_vld` is 0 and `disp_mask` is 0.
- R2: A fetch packet is taken on a clock edge where `fetch_req` and `fetch_vld` are both 1. Its first execute packet appears on the dispatch outputs after that edge. `fetch_req` stays 0 for as long as `disp_vld` is 1.
- R3: `disp_mask` has bit i set for each slot i in the current execute packet. The set bits form one contiguous run. The run begins at the first slot not yet issued and ends at the first slot, counting upward from there, whose bit 0 is 0.
- R4: Bit 0 of slot 7 (bit 224 of the fetch packet) is treated as 0. A fetch packet whose slot-7 chaining bit is 1 therefore still closes its last execute packet at slot 7.
- R5: Lane i of `disp_insn` (bits 32*i+31 down to 32*i) carries the instruction from slot i when `disp_mask[i]` is 1, and carries all zeros otherwise.
- R6: With `stall` at 0, a new execute packet is issued on every clock. Each execute packet starts at the slot just above the last slot of the previous one. A fetch packet therefore takes one issue cycle plus one more for each 0 chaining bit in slots 0 to 6, which is between one and eight cycles.
- R7: While `stall` is 1, `disp_vld`, `disp_mask` and `disp_insn` keep their values and no execute packet is consumed.
- R8: On the clock after the execute packet that contains slot 7 is issued, `disp_vld` is 0 and `fetch_req` is 1.
- R9: `fetch_vld` and `fetch_data` are ignored while `fetch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | output | 1 | Block is empty and requests a fetch packet |
| fetch_vld | input | 1 | Program memory presents a fetch packet |
| fetch_data | input | 256 | Fetch packet, slot 0 in the lowest 32 bits |
| stall | input | 1 | Hold the current execute packet |
| disp_vld | output | 1 | An execute packet is on the dispatch outputs |
| disp_mask | output | 8 | Slots that belong to the current execute packet |
| disp_insn | output | 256 | Instructions in their own lanes, zero outside the mask |

## Verification
The assertions assume three things about the inputs: `rst_n` is applied before the first checked edge, `stall` changes only away from the active edge, and `fetch_data` is stable whenever it is presented with `fetch_vld`. The stimulus meets these assumptions. It changes every input on the falling clock edge, and it offers a fetch packet only after it has seen `fetch_req` high. The one exception is deliberate. In the stall test, the bench drives `fetch_vld` with unrelated data while a fetch packet is still held, and it checks that the dispatch outputs do not move.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;
  typedef enum logic {
    HOLD_EMPTY = 1'b0,
    HOLD_BUSY  = 1'b1
  } hold_state_e;
endpackage

// File: rtl/chain_scan.sv
module chain_scan #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned PTR_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain,
  input  logic [PTR_W-1:0] start,
  output logic [SLOTS-1:0] mask,
  output logic             last,
  output logic [PTR_W-1:0] next_start
);
  function automatic logic [SLOTS-1:0] span_mask(input logic [SLOTS-1:0] ch,
                                                  input logic [PTR_W-1:0] st);
    logic [SLOTS-1:0] m;
    logic open, closed;
    m = '0;
    open = 1'b0;
    closed = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (PTR_W'(i) == st) open = 1'b1;
      if (open && !closed) begin
        m[i] = 1'b1;
        if (!ch[i] || i == SLOTS - 1) closed = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [PTR_W-1:0] step_start(input logic [PTR_W-1:0] st,
                                                  input logic [SLOTS-1:0] m);
    logic [PTR_W:0] sum;
    sum = {1'b0, st};
    for (int i = 0; i < SLOTS; i++) sum = sum + (PTR_W + 1)'(m[i]);
    return sum[PTR_W-1:0];
  endfunction

  always_comb begin
    mask       = span_mask(chain, start);
    last       = mask[SLOTS-1];
    next_start = step_start(start, mask);
  end
endmodule

// File: rtl/slot_gate.sv
module slot_gate #(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned CHAIN_POS = 0
) (
  input  logic [SLOTS*INSN_W-1:0] bundle,
  input  logic [SLOTS-1:0]        mask,
  output logic [SLOTS*INSN_W-1:0] lanes,
  output logic [SLOTS-1:0]        chain
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign chain[g] = bundle[g*INSN_W + CHAIN_POS];
    assign lanes[g*INSN_W +: INSN_W] = mask[g] ? bundle[g*INSN_W +: INSN_W] : '0;
  end
endmodule

// File: rtl/packet_hold.sv
module packet_hold
  import vliw_disp_pkg::*;
#(
  parameter int unsigned FETCH_W = 256,
  parameter int unsigned PTR_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FETCH_W-1:0] data,
  input  logic               advance,
  input  logic               last,
  input  logic [PTR_W-1:0]   next_start,
  output logic               full,
  output logic [FETCH_W-1:0] bundle,
  output logic [PTR_W-1:0]   start
);
  hold_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HOLD_EMPTY;
      bundle  <= '0;
      start   <= '0;
    end else if (load) begin
      state_q <= HOLD_BUSY;
      bundle  <= data;
      start   <= '0;
    end else if (advance) begin
      if (last) state_q <= HOLD_EMPTY;
      start <= last ? '0 : next_start;
    end
  end

  assign full = (state_q == HOLD_BUSY);
endmodule

// File: rtl/exec_bundle_dispatch.sv
module exec_bundle_dispatch #(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned CHAIN_POS = 0,
  localparam int unsigned FETCH_W  = SLOTS * INSN_W,
  localparam int unsigned PTR_W    = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               fetch_req,
  input  logic               fetch_vld,
  input  logic [FETCH_W-1:0] fetch_data,
  input  logic               stall,
  output logic               disp_vld,
  output logic [SLOTS-1:0]   disp_mask,
  output logic [FETCH_W-1:0] disp_insn
);
  logic               held;
  logic [FETCH_W-1:0] bundle;
  logic [PTR_W-1:0]   start;
  logic [SLOTS-1:0]   chain;
  logic [SLOTS-1:0]   span;
  logic [FETCH_W-1:0] lanes;
  logic [PTR_W-1:0]   next_start;

  // named events for the checker
  logic fetch_take;
  logic issue_fire;
  logic packet_last;

  assign fetch_req  = !held;
  assign fetch_take = fetch_req && fetch_vld;
  assign issue_fire = held && !stall;

  packet_hold #(.FETCH_W(FETCH_W), .PTR_W(PTR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(fetch_take), .data(fetch_data),
    .advance(issue_fire), .last(packet_last), .next_start(next_start),
    .full(held), .bundle(bundle), .start(start)
  );

  chain_scan #(.SLOTS(SLOTS)) u_scan (
    .chain(chain), .start(start), .mask(span),
    .last(packet_last), .next_start(next_start)
  );

  slot_gate #(.SLOTS(SLOTS), .INSN_W(INSN_W), .CHAIN_POS(CHAIN_POS)) u_gate (
    .bundle(bundle), .mask(span), .lanes(lanes), .chain(chain)
  );

  assign disp_vld  = held;
  assign disp_mask = held ? span : '0;
  assign disp_insn = held ? lanes : '0;
endmodule

// File: rtl/exec_bundle_dispatch_chk.sv
module exec_bundle_dispatch_chk #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned INSN_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_req,
  input logic                    stall,
  input logic                    disp_vld,
  input logic [SLOTS-1:0]        disp_mask,
  input logic [SLOTS*INSN_W-1:0] disp_insn,
  input logic                    issue_fire,
  input logic                    packet_last
);
  function automatic logic [SLOTS*INSN_W-1:0] widen(input logic [SLOTS-1:0] m);
    logic [SLOTS*INSN_W-1:0] w;
    for (int i = 0; i < SLOTS; i++) w[i*INSN_W +: INSN_W] = {INSN_W{m[i]}};
    return w;
  endfunction

  logic [SLOTS-1:0] low_bit;
  assign low_bit = disp_mask & (~disp_mask + 1'b1);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld |-> !fetch_req); // R2
  AST_IDLE_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_vld |-> (fetch_req && disp_mask == '0)); // R1
  AST_MASK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld |-> (disp_mask != '0 && ((disp_mask + low_bit) & disp_mask) == '0)); // R3
  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_insn & ~widen(disp_mask)) == '0); // R5
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !packet_last) |=> (disp_vld && $past(disp_mask) < disp_mask)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld && stall) |=> (disp_vld && $stable(disp_mask) && $stable(disp_insn))); // R7
  AST_TAIL_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld && !stall && disp_mask[SLOTS-1]) |=> (fetch_req && !disp_vld)); // R8
endmodule

bind exec_bundle_dispatch exec_bundle_dispatch_chk #(.SLOTS(SLOTS), .INSN_W(INSN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .stall(stall),
  .disp_vld(disp_vld), .disp_mask(disp_mask), .disp_insn(disp_insn),
  .issue_fire(issue_fire), .packet_last(packet_last)
);

// File: tb/sim_exec_bundle_dispatch.sv
module sim_exec_bundle_dispatch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_req;
  logic         fetch_vld = 1'b0;
  logic [255:0] fetch_data = '0;
  logic         stall = 1'b0;
  logic         disp_vld;
  logic [7:0]   disp_mask;
  logic [255:0] disp_insn;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  exec_bundle_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_vld(fetch_vld),
    .fetch_data(fetch_data), .stall(stall), .disp_vld(disp_vld),
    .disp_mask(disp_mask), .disp_insn(disp_insn)
  );

  // {chain bits of slots 7..0, issue cycles, expected masks packed 8 bits per packet}
  localparam logic [79:0] VEC [6] = '{
    {8'h00, 8'd8, 64'h8040201008040201},
    {8'hFF, 8'd1, 64'h00000000000000FF},
    {8'h0F, 8'd4, 64'h000000008040201F},
    {8'h55, 8'd4, 64'h00000000C0300C03},
    {8'hA0, 8'd7, 64'h0080601008040201},
    {8'h80, 8'd8, 64'h8040201008040201}
  };

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] make_bundle(input logic [7:0] ch, input int tag);
    logic [255:0] b;
    for (int i = 0; i < 8; i++) b[i*32 +: 32] = {8'(tag), 8'(i), 15'h2A5B, ch[i]};
    return b;
  endfunction

  function automatic logic [255:0] keep_lanes(input logic [255:0] b, input logic [7:0] m);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = m[i] ? b[i*32 +: 32] : 32'h0;
    return r;
  endfunction

  task automatic offer(input logic [255:0] b);
    check(fetch_req === 1'b1, "R2 request before offer", 256'(fetch_req), 256'd1);
    fetch_vld  = 1'b1;
    fetch_data = b;
    @(posedge clk);
    @(negedge clk);
    fetch_vld  = 1'b0;
    fetch_data = '0;
  endtask

  task automatic run_vector(input int v);
    logic [7:0]   ch  = VEC[v][79:72];
    int           cnt = int'(VEC[v][71:64]);
    logic [255:0] b   = make_bundle(ch, v + 1);
    offer(b);
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] em = VEC[v][k*8 +: 8];
      check(disp_vld === 1'b1 && fetch_req === 1'b0, "R2 R6 issue valid",
            256'({disp_vld, fetch_req}), 256'(2'b10));
      check(disp_mask === em, "R3 R4 R6 mask", 256'(disp_mask), 256'(em));
      check(disp_insn === keep_lanes(b, em), "R5 lanes", disp_insn, keep_lanes(b, em));
      @(posedge clk);
      @(negedge clk);
    end
    check(disp_vld === 1'b0 && fetch_req === 1'b1, "R8 refetch after tail",
          256'({disp_vld, fetch_req}), 256'(2'b01));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [255:0] b;
    logic [255:0] hold_exp;
    repeat (3) @(negedge clk);
    check(fetch_req === 1'b1 && disp_vld === 1'b0 && disp_mask === 8'h00, "R1 reset state",
          256'({fetch_req, disp_vld, disp_mask}), 256'(10'h200));
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_req === 1'b1 && disp_vld === 1'b0, "R1 idle after release",
          256'({fetch_req, disp_vld}), 256'(2'b10));

    for (int v = 0; v < 6; v++) run_vector(v);

    // R7 stall hold and R9 ignored offer while busy
    b = make_bundle(8'h0F, 9);
    offer(b);
    hold_exp = keep_lanes(b, 8'h1F);
    stall      = 1'b1;
    fetch_vld  = 1'b1;
    fetch_data = make_bundle(8'h00, 12);
    for (int s = 0; s < 3; s++) begin
      @(posedge clk);
      @(negedge clk);
      check(disp_vld === 1'b1 && disp_mask === 8'h1F, "R7 stall holds mask",
            256'(disp_mask), 256'(8'h1F));
      check(disp_insn === hold_exp, "R7 R9 stall holds lanes", disp_insn, hold_exp);
      check(fetch_req === 1'b0, "R9 no request while busy", 256'(fetch_req), 256'd0);
    end
    stall = 1'b0;
    @(posedge clk);
    @(negedge clk);
    fetch_vld  = 1'b0;
    fetch_data = '0;
    check(disp_mask === 8'h20, "R6 R9 resume after stall", 256'(disp_mask), 256'(8'h20));
    check(disp_insn === keep_lanes(b, 8'h20), "R9 busy offer ignored", disp_insn,
          keep_lanes(b, 8'h20));
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(disp_mask === 8'h80, "R4 tail slot", 256'(disp_mask), 256'(8'h80));
    @(posedge clk);
    @(negedge clk);
    check(disp_vld === 1'b0 && fetch_req === 1'b1, "R8 empty after stall run",
          256'({disp_vld, fetch_req}), 256'(2'b01));

    // R1 reset in the middle of a fetch packet
    offer(make_bundle(8'h00, 14));
    rst_n = 1'b0;
    @(negedge clk);
    check(disp_vld === 1'b0 && fetch_req === 1'b1, "R1 mid-run reset",
          256'({disp_vld, fetch_req}), 256'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);
    run_vector(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule